// File: doc/BRIEF.md
# Synchronous Burst Pipelined SRAM

This block models a single-clock synchronous static RAM with a 64-bit word split into eight byte lanes and a 16-bit word address. The array depth is a parameter, so only the low address bits index storage and the model stays small in simulation. An access begins when one of two active-low address strobes is sampled low with the chip enable active. One strobe comes from the processor and the other from the system chipset. The address presented in that cycle is registered. Each later clock edge is a data cycle on the current burst word. The word reads, or writes when the write controls sampled in that same cycle ask for it.

A 2-bit counter walks the burst in interleaved order. It advances after each data cycle in which the active-low advance input is low. Writes come in two forms. A per-lane write uses a write enable and eight lane enables. A global write stores all lanes. All write controls travel with the data, one cycle after the address. Read data is registered and appears one clock after its data cycle. The output drivers are enabled only when the asynchronous output enable is low and the last data cycle was a read.

Top module: `sbp_sram`

## Requirements
- R1: After reset no burst is active and `rdata_oe` is 0. Until an enabled strobe arrives, clock edges neither read nor write, even with write controls active.
- R2: A strobe sampled low with `ce_n` low registers `addr`. In the next cycle (the first data cycle) the stored word at that address is read and appears on `rdata` after that cycle's clock edge.
- R3: The n-th data cycle after advances targets the word whose upper address bits equal the start address. Its low two bits equal the start low bits XOR the advance count (0, 1, 2, 3).
- R4: A data cycle with `adv_n` high leaves the burst address unchanged, so the next data cycle targets the same word.
- R5: In a data cycle with `gw_n` high and `bwe_n` low, lane i (bits 8i+7..8i) is written from `wdata` exactly when `bw_n[i]` is 0. The other lanes keep their contents, and `bw_n` all ones writes nothing.
- R6: In a data cycle with `gw_n` low, all eight lanes are written, whatever `bwe_n` and `bw_n` hold.
- R7: Write controls and `wdata` sampled in a strobe cycle have no effect. Only those sampled in a data cycle decide whether, and which lanes, are written.
- R8: The first data cycle after a processor strobe (`ads_cpu_n`) is always a read. A chipset strobe (`ads_chip_n`) lets its first data cycle write.
- R9: When both strobes are low in the same cycle, the processor strobe wins, so the first data cycle reads.
- R10: A strobe sampled while `ce_n` is high starts nothing and ends any burst in progress. Later edges neither read nor write, and `rdata_oe` stays 0.
- R11: `rdata_oe` is 1 only while `oe_n` is low and the most recent data cycle was a read. It follows `oe_n` without waiting for a clock. A write cycle or a strobe cycle drops it after that edge.
- R12: After four advances the burst address wraps back to the start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Word address, registered on a strobe |
| ce_n | input | 1 | Chip enable, active low, sampled with the strobes |
| ads_cpu_n | input | 1 | Processor address strobe, active low |
| ads_chip_n | input | 1 | Chipset address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bw_n | input | 8 | Per-lane enables, active low, bit i for byte lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 64 | Write data, sampled in data cycles |
| rdata | output | 64 | Registered read data |
| rdata_oe | output | 1 | Drive enable for `rdata` on a shared bus |

## Verification
A strobe result is due at the first negative edge after the strobe edge, and it is always a disabled output. A data-cycle read shows on `rdata` at the negative edge after that data cycle's rising edge, so its latency is one clock from the data cycle and two clocks from the strobe. A write's effect is seen only through a later read burst. The driver tags each expectation with the cycle number at which it falls due. The monitor pops expectations one time unit after each falling edge, only once the cycle count reaches that number. The effect of `oe_n` is checked between edges, with no clock involved.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_CHIP = 2'd2
    } strb_src_e;

    typedef struct packed {
        logic       act;       // a burst is open
        logic       first_rd;  // next data cycle must read
        logic [1:0] cnt;       // interleave count
    } burst_st_t;

    typedef struct packed {
        logic wr_fire;
        logic rd_fire;
    } cyc_kind_t;

    // processor strobe has priority over chipset strobe
    function automatic strb_src_e pick_src(logic cpu_lo, logic chip_lo);
        if (cpu_lo)       return SRC_CPU;
        else if (chip_lo) return SRC_CHIP;
        else              return SRC_NONE;
    endfunction

    function automatic logic [1:0] ilv_low(logic [1:0] start, logic [1:0] cnt);
        return start ^ cnt;
    endfunction

endpackage

// File: rtl/sbp_addr_ctl.sv
module sbp_addr_ctl
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ads_cpu_n,
    input  logic              ads_chip_n,
    input  logic              adv_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              new_cyc,
    output logic              data_cyc,
    output logic              first_rd,
    output logic              burst_act
);

    strb_src_e         src;
    burst_st_t         st_q;
    logic [ADDR_W-1:0] base_q;

    assign src     = pick_src(!ads_cpu_n, !ads_chip_n);
    assign new_cyc = (src != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            base_q <= '0;
        end else if (new_cyc) begin
            base_q      <= addr;
            st_q.cnt    <= 2'd0;
            st_q.act    <= !ce_n;
            st_q.first_rd <= !ce_n && (src == SRC_CPU);
        end else if (st_q.act) begin
            st_q.first_rd <= 1'b0;
            if (!adv_n) begin
                st_q.cnt <= 2'(st_q.cnt + 2'd1);
            end
        end
    end

    assign cur_addr  = {base_q[ADDR_W-1:2], ilv_low(base_q[1:0], st_q.cnt)};
    assign data_cyc  = st_q.act && !new_cyc;
    assign first_rd  = st_q.first_rd;
    assign burst_act = st_q.act;

endmodule

// File: rtl/sbp_wr_decode.sv
module sbp_wr_decode
    import sbp_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             data_cyc,
    input  logic             first_rd,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we,
    output cyc_kind_t        kind
);

    logic wr_req;

    assign wr_req       = !gw_n || !bwe_n;
    assign kind.wr_fire = data_cyc && !first_rd && wr_req;
    assign kind.rd_fire = data_cyc && !kind.wr_fire;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (!kind.wr_fire)  lane_we[i] = 1'b0;
            else if (!gw_n)     lane_we[i] = 1'b1;
            else                lane_we[i] = !bw_n[i];
        end
    end

endmodule

// File: rtl/sbp_mem_core.sv
module sbp_mem_core #(
    parameter int ADDR_W  = 16,
    parameter int DEPTH_W = 8,
    parameter int LANES   = 8,
    parameter int LANE_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    rd_fire,
    output logic [LANES*LANE_W-1:0] rdata_q,
    output logic                    rd_vld_q
);

    localparam int DEPTH = 1 << DEPTH_W;

    logic [DEPTH_W-1:0] idx;
    logic               unused_hi;

    assign idx       = addr[DEPTH_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:DEPTH_W];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[l]) begin
                mem_q[idx] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst)          rdata_q[l*LANE_W +: LANE_W] <= '0;
            else if (rd_fire) rdata_q[l*LANE_W +: LANE_W] <= mem_q[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld_q <= 1'b0;
        else     rd_vld_q <= rd_fire;
    end

endmodule

// File: rtl/sbp_sram.sv
module sbp_sram
    import sbp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DEPTH_W = 8,
    parameter int LANES   = 8,
    parameter int LANE_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_n,
    input  logic                    ads_cpu_n,
    input  logic                    ads_chip_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    logic [ADDR_W-1:0] cur_addr;
    logic              new_cyc;
    logic              data_cyc;
    logic              first_rd;
    logic              burst_act;
    logic [LANES-1:0]  lane_we;
    cyc_kind_t         kind;
    logic              rd_vld;

    sbp_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .ce_n       (ce_n),
        .ads_cpu_n  (ads_cpu_n),
        .ads_chip_n (ads_chip_n),
        .adv_n      (adv_n),
        .cur_addr   (cur_addr),
        .new_cyc    (new_cyc),
        .data_cyc   (data_cyc),
        .first_rd   (first_rd),
        .burst_act  (burst_act)
    );

    sbp_wr_decode #(.LANES(LANES)) u_wdec (
        .data_cyc (data_cyc),
        .first_rd (first_rd),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .lane_we  (lane_we),
        .kind     (kind)
    );

    sbp_mem_core #(
        .ADDR_W  (ADDR_W),
        .DEPTH_W (DEPTH_W),
        .LANES   (LANES),
        .LANE_W  (LANE_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .addr     (cur_addr),
        .wdata    (wdata),
        .lane_we  (lane_we),
        .rd_fire  (kind.rd_fire),
        .rdata_q  (rdata),
        .rd_vld_q (rd_vld)
    );

    assign rdata_oe = !oe_n && rd_vld;

endmodule

// File: rtl/sbp_sram_chk.sv
module sbp_sram_chk #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              ads_cpu_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic [LANES-1:0]  bw_n,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              new_cyc,
    input logic              burst_act,
    input logic [LANES-1:0]  lane_we,
    input logic              wr_fire,
    input logic              rd_vld
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!rd_vld && !burst_act));

    // R3: an advance keeps the upper bits and moves the low two bits
    assert_interleave_R3: assert property (@(posedge clk) disable iff (rst)
        (burst_act && !new_cyc && !adv_n) |=>
            (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]) &&
             cur_addr[1:0] != $past(cur_addr[1:0])));

    assert_hold_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (burst_act && !new_cyc && adv_n) |=> $stable(cur_addr));

    assert_lane_select_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && gw_n) |-> (lane_we == ~bw_n));

    assert_global_all_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !gw_n) |-> (&lane_we));

    assert_no_strobe_write_R7: assert property (@(posedge clk) disable iff (rst)
        new_cyc |-> (lane_we == '0));

    assert_cpu_first_read_R8: assert property (@(posedge clk) disable iff (rst)
        (!ads_cpu_n && !ce_n) |=> !wr_fire);

    assert_ce_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (new_cyc && ce_n) |=> !burst_act);

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> !rd_vld);

endmodule

bind sbp_sram sbp_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .ads_cpu_n (ads_cpu_n),
    .adv_n     (adv_n),
    .gw_n      (gw_n),
    .bw_n      (bw_n),
    .cur_addr  (cur_addr),
    .new_cyc   (new_cyc),
    .burst_act (burst_act),
    .lane_we   (lane_we),
    .wr_fire   (kind.wr_fire),
    .rd_vld    (rd_vld)
);

// File: tb/sbp_sram_tb.sv
module sbp_sram_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int DW     = LANES * LANE_W;
    localparam logic [DW-1:0] JUNK = 64'hDEAD_BEEF_BAAD_F00D;

    logic              clk;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic              ce_n, ads_cpu_n, ads_chip_n, adv_n, gw_n, bwe_n, oe_n;
    logic [LANES-1:0]  bw_n;
    logic [DW-1:0]     wdata;
    logic [DW-1:0]     rdata;
    logic              rdata_oe;

    sbp_sram #(.ADDR_W(ADDR_W), .DEPTH_W(8), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n),
        .ads_cpu_n(ads_cpu_n), .ads_chip_n(ads_chip_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc_cnt = 0;
    always @(posedge clk) cyc_cnt++;

    typedef struct {
        int            due;
        bit            en;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            ended = 0;
    logic [DW-1:0] ref_mem [int];

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a, int k);
        return {8{8'(a * 7 + k * 13 + 1)}} ^ 64'h0F1E_2D3C_4B5A_6978;
    endfunction

    function automatic void ref_wr(int a, logic [LANES-1:0] on, logic [DW-1:0] d);
        logic [DW-1:0] t;
        t = ref_mem.exists(a) ? ref_mem[a] : '0;
        for (int l = 0; l < LANES; l++)
            if (on[l]) t[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        ref_mem[a] = t;
    endfunction

    function automatic void push(bit en, logic [DW-1:0] d, string tag);
        exp_t e;
        e.due = cyc_cnt + 1;
        e.en = en;
        e.data = d;
        e.tag = tag;
        sb_q.push_back(e);
    endfunction

    // monitor: compare results one time unit after each falling edge
    always @(negedge clk) begin
        exp_t e;
        #1;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc_cnt) begin
            e = sb_q.pop_front();
            check({e.tag, " oe"}, DW'(rdata_oe), DW'(e.en));
            if (e.en) check({e.tag, " data"}, rdata, e.data);
        end
    end

    task automatic idle_ctl();
        ads_cpu_n = 1; ads_chip_n = 1; ce_n = 0; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = '1; wdata = '0;
    endtask

    // src: 0 chipset, 1 processor, 2 both
    task automatic strobe(int src, int a, bit ce, bit dirty, string tag);
        idle_ctl();
        addr = ADDR_W'(a);
        ce_n = !ce;
        if (src != 0) ads_cpu_n = 0;
        if (src != 1) ads_chip_n = 0;
        if (dirty) begin gw_n = 0; bwe_n = 0; bw_n = '0; wdata = JUNK; end
        push(0, '0, tag);
        @(negedge clk);
    endtask

    task automatic data(bit adv, bit gw, bit bwe, logic [LANES-1:0] bw,
                        logic [DW-1:0] d, bit exp_rd, logic [DW-1:0] exp, string tag);
        idle_ctl();
        adv_n = !adv; gw_n = !gw; bwe_n = !bwe; bw_n = bw; wdata = d;
        push(exp_rd, exp, tag);
        @(negedge clk);
    endtask

    task automatic rd(bit adv, int a, string tag);
        data(adv, 0, 0, '1, '0, 1, ref_mem[a], tag);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1; oe_n = 0; addr = '0;
        idle_ctl();
        repeat (3) @(negedge clk);
        rst = 0;
        #1 check("R1 reset oe", DW'(rdata_oe), '0);
        @(negedge clk);
        data(1, 1, 0, '1, JUNK, 0, '0, "R1 no burst after reset");

        // fill 0x10..0x13 from start 0x12 via chipset strobe, global write
        strobe(0, 'h12, 1, 0, "R8 chipset strobe");
        data(1, 1, 1, '1, pat('h12, 0), 0, '0, "R8 chipset first cycle writes");
        data(1, 1, 1, '1, pat('h13, 0), 0, '0, "R11 write disables output");
        data(1, 1, 1, '1, pat('h10, 0), 0, '0, "R6 fill");
        data(1, 1, 1, '1, pat('h11, 0), 0, '0, "R6 fill");
        ref_wr('h12, '1, pat('h12, 0)); ref_wr('h13, '1, pat('h13, 0));
        ref_wr('h10, '1, pat('h10, 0)); ref_wr('h11, '1, pat('h11, 0));

        // interleaved read burst from 0x11 and wrap
        strobe(1, 'h11, 1, 0, "R2 processor strobe");
        rd(1, 'h11, "R2 first word");
        rd(1, 'h10, "R3 second word");
        rd(1, 'h13, "R3 third word");
        rd(1, 'h12, "R3 fourth word");
        rd(1, 'h11, "R12 wrap to start");

        // hold with advance high
        strobe(0, 'h13, 1, 0, "R4 strobe");
        rd(0, 'h13, "R4 hold first");
        rd(0, 'h13, "R4 hold repeat");
        rd(1, 'h13, "R4 hold then advance");
        rd(0, 'h12, "R4 advanced word");

        // asynchronous output enable, no clock edge in between
        #2 oe_n = 1;
        #1 check("R11 oe high gates output", DW'(rdata_oe), '0);
        oe_n = 0;
        #1 check("R11 oe low restores output", DW'(rdata_oe), DW'(1));
        @(negedge clk);

        // per-lane write on 0x10, empty lane set on 0x11
        strobe(0, 'h10, 1, 0, "R5 strobe");
        data(1, 0, 1, 8'b1010_1010, {8{8'hEE}}, 0, '0, "R5 lane write");
        data(1, 0, 1, 8'hFF, JUNK, 0, '0, "R5 empty lane write");
        ref_wr('h10, 8'b0101_0101, {8{8'hEE}});
        strobe(0, 'h10, 1, 0, "R5 readback strobe");
        rd(1, 'h10, "R5 selected lanes only");
        rd(1, 'h11, "R5 no lane written");

        // global write overrides lane enables
        strobe(0, 'h13, 1, 0, "R6 strobe");
        data(0, 1, 1, 8'b1111_0000, pat('h13, 2), 0, '0, "R6 global write");
        ref_wr('h13, '1, pat('h13, 2));
        strobe(0, 'h13, 1, 0, "R6 readback strobe");
        rd(0, 'h13, "R6 all lanes written");

        // write controls in strobe cycle do nothing
        strobe(0, 'h12, 1, 1, "R7 dirty strobe");
        rd(0, 'h12, "R7 strobe-cycle write ignored");

        // processor strobe first access is a read
        strobe(1, 'h12, 1, 0, "R8 processor strobe");
        data(1, 1, 0, '1, JUNK, 1, ref_mem['h12], "R8 first access reads");
        data(1, 1, 0, '1, pat('h13, 3), 0, '0, "R8 second access writes");
        ref_wr('h13, '1, pat('h13, 3));
        strobe(0, 'h13, 1, 0, "R8 readback strobe");
        rd(0, 'h13, "R8 second access stored");

        // both strobes: processor wins
        strobe(2, 'h10, 1, 0, "R9 both strobes");
        data(0, 1, 0, '1, JUNK, 1, ref_mem['h10], "R9 processor priority read");

        // chip enable inactive
        strobe(0, 'h11, 0, 0, "R10 disabled strobe");
        data(1, 1, 0, '1, JUNK, 0, '0, "R10 no write");
        data(1, 0, 0, '1, '0, 0, '0, "R10 no read");
        strobe(0, 'h11, 1, 0, "R10 readback strobe");
        rd(0, 'h11, "R10 word unchanged");
        strobe(1, 'h12, 0, 0, "R10 disabled strobe ends burst");
        data(1, 0, 0, '1, '0, 0, '0, "R10 burst cleared");

        repeat (3) @(negedge clk);
        #2;
        summary();
        $finish;
    end

endmodule